// File: doc/BRIEF.md
# Host-Port Remote Memory Access Bridge

This block sits between an external host and a processor core. It lets the host read or write any word of the processor's memory without the core's program taking part, apart from a short service routine. The host pushes words into a one-word transmit slot (TX). Each push carries a function code. The code marks the word as a plain word, as part of a remote memory write, or as the address of a remote memory read. A word in TX moves by itself into the processor-side receive slot (HRX) as soon as HRX is empty. When a tagged word lands there, the block pulses a service request towards the processor.

For a remote read, the host sends the address once, tagged as a read. That push raises a pending-read flag. The processor's service routine takes the address from HRX, fetches the word from memory and writes it to the processor-side transmit port (HTX). The word then appears in the host-side receive register (RX). The receive-full flag rises and drives the host request line, and the pending-read flag drops. For a remote write, the host sends two write-tagged words in turn, the address and then the data. A two-state sequencer keeps track of which is which, and only the data word raises the write service request.

The sequencer has two states. In SQ_IDLE no write is under way. SQ_WAIT_DATA means a write address has landed and the data word is awaited. The transition SQ_IDLE to SQ_WAIT_DATA happens when a write-tagged word lands. The transition SQ_WAIT_DATA to SQ_IDLE happens when the next write-tagged word lands, and it fires the write request. Each of the TX, HRX and RX slots is a two-state machine as well. TX moves TX_EMPTY to TX_HOLD on an accepted push and back to TX_EMPTY on a move into HRX. HRX moves HRX_EMPTY to HRX_FULL on a move from TX and back to HRX_EMPTY on a processor read. RX moves RX_EMPTY to RX_FULL on an HTX write and back to RX_EMPTY on a host read.

Top module: `hpmem_bridge`

## Requirements
- R1: `host_tx_func` uses these codes: 2'b00 plain, 2'b01 memory-write, 2'b10 memory-read, 2'b11 clear-error. A push with any code other than 2'b11 while `tx_empty`=1 is accepted, and `tx_empty` is 0 in the next cycle.
- R2: A word held in TX while HRX is empty moves to HRX on the next clock edge. In that cycle `tx_empty` returns to 1, `proc_hrx_full` becomes 1, and `proc_hrx_data` shows the word.
- R3: `proc_hrx_re` while HRX is full empties HRX for the next cycle. A word waiting in TX then moves into HRX on the following edge.
- R4: `tx_ready` is 1 exactly when both TX and HRX are empty.
- R5: An accepted memory-read push sets `rd_pending` in the next cycle. When that word lands in HRX, `svc_mrd` is high for exactly that one cycle.
- R6: `proc_htx_we` loads `host_rx_data` with `proc_htx_data` for the next cycle. In that cycle `rx_full`=1, `host_req`=1 and `rd_pending`=0.
- R7: `host_rx_re` clears `rx_full` and `host_req` for the next cycle. If `proc_htx_we` comes in the same cycle, the new word wins and `rx_full` stays 1.
- R8: The first memory-write word to land is the address. It raises no request and sets `wr_await_data`. The next memory-write word to land is the data: `svc_mwr` is high for one cycle and `wr_await_data` returns to 0.
- R9: A plain word lands in HRX without raising either service request.
- R10: A push with a code other than 2'b11 while `tx_empty`=0 is dropped, leaving TX unchanged, and sets `ovr_err` from the next cycle on. `ovr_err` stays set until a clear-error push, after which it is 0 in the next cycle. A clear-error push never loads TX.
- R11: A host that pushes an address while `tx_ready`=1 and leaves one idle cycle before pushing the data has the data accepted without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_tx_we | input | 1 | Host push into TX |
| host_tx_func | input | 2 | Function code of the push |
| host_tx_data | input | DW | Pushed word |
| host_rx_re | input | 1 | Host read of RX |
| host_rx_data | output | DW | RX word |
| tx_empty | output | 1 | TX slot is empty |
| tx_ready | output | 1 | TX and HRX are both empty |
| rx_full | output | 1 | RX holds an unread word |
| host_req | output | 1 | Host request line |
| ovr_err | output | 1 | Sticky overrun error |
| rd_pending | output | 1 | Remote read awaiting data |
| proc_hrx_re | input | 1 | Processor read of HRX |
| proc_hrx_data | output | DW | HRX word |
| proc_hrx_full | output | 1 | HRX holds a word |
| proc_htx_we | input | 1 | Processor write to HTX |
| proc_htx_data | input | DW | Word written to HTX |
| svc_mwr | output | 1 | Memory-write service request pulse |
| svc_mrd | output | 1 | Memory-read service request pulse |
| wr_await_data | output | 1 | Write address taken, data awaited |

## Verification
Each result falls due at a fixed number of edges after its stimulus. An accepted or dropped push shows in `tx_empty`, `ovr_err` and `rd_pending` one edge later. A landing in HRX shows one edge after that, or one edge after the processor read that freed HRX, and the service pulse appears in that same cycle. HTX writes and host RX reads take effect one edge later. The bench drives every input one nanosecond after a rising edge and samples after the edge that is due. The count of edges is thereby exact, and the bench also checks that each pulse has gone one edge later.

// File: rtl/hpmem_pkg.sv
package hpmem_pkg;
    localparam int FUNC_W = 2;

    typedef enum logic [FUNC_W-1:0] {
        FN_PLAIN  = 2'b00,
        FN_MEMWR  = 2'b01,
        FN_MEMRD  = 2'b10,
        FN_CLRERR = 2'b11
    } hp_func_e;
endpackage

// File: rtl/hp_tx_slot.sv
module hp_tx_slot
    import hpmem_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  hp_func_e      func,
    input  logic [DW-1:0] din,
    input  logic          drain,
    output logic          full,
    output logic [DW-1:0] word,
    output hp_func_e      tag,
    output logic          err,
    output logic          rd_set
);
    typedef enum logic {TX_EMPTY, TX_HOLD} tx_st_e;
    tx_st_e st, st_nx;

    logic push, accept, clr;
    assign push   = wr && (func != FN_CLRERR);
    assign clr    = wr && (func == FN_CLRERR);
    assign accept = push && (st == TX_EMPTY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_EMPTY;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_EMPTY: if (accept) st_nx = TX_HOLD;
            TX_HOLD:  if (drain)  st_nx = TX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            tag  <= FN_PLAIN;
            err  <= 1'b0;
        end else begin
            if (accept) begin
                word <= din;
                tag  <= func;
            end
            if (clr)
                err <= 1'b0;
            else if (push && st == TX_HOLD)
                err <= 1'b1;
        end
    end

    assign full   = (st == TX_HOLD);
    assign rd_set = accept && (func == FN_MEMRD);

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> full);
    p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (err && $stable(word)));
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!err && $stable(word)));
endmodule

// File: rtl/hp_hrx_slot.sv
module hp_hrx_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          rd,
    output logic          full,
    output logic [DW-1:0] data
);
    typedef enum logic {HRX_EMPTY, HRX_FULL} hrx_st_e;
    hrx_st_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= HRX_EMPTY;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            HRX_EMPTY: if (load) st_nx = HRX_FULL;
            HRX_FULL:  if (rd)   st_nx = HRX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       data <= '0;
        else if (load && st == HRX_EMPTY) data <= din;
    end

    assign full = (st == HRX_FULL);

    p_land_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !full) |=> (full && data == $past(din)));
    p_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd) |=> !full);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd) |=> (full && $stable(data)));
endmodule

// File: rtl/hp_wr_seq.sv
module hp_wr_seq
    import hpmem_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     land,
    input  hp_func_e land_tag,
    output logic     svc_mwr,
    output logic     svc_mrd,
    output logic     await_data
);
    typedef enum logic {SQ_IDLE, SQ_WAIT_DATA} sq_st_e;
    sq_st_e st, st_nx;

    logic land_wr, land_rd;
    assign land_wr = land && (land_tag == FN_MEMWR);
    assign land_rd = land && (land_tag == FN_MEMRD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_IDLE:      if (land_wr) st_nx = SQ_WAIT_DATA;
            SQ_WAIT_DATA: if (land_wr) st_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_mwr <= 1'b0;
            svc_mrd <= 1'b0;
        end else begin
            svc_mwr <= land_wr && (st == SQ_WAIT_DATA);
            svc_mrd <= land_rd;
        end
    end

    assign await_data = (st == SQ_WAIT_DATA);

    p_addr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (land_wr && !await_data) |=> (!svc_mwr && await_data));
    p_data_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (land_wr && await_data) |=> (svc_mwr && !await_data));
    p_plain_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (land && land_tag == FN_PLAIN) |=> (!svc_mwr && !svc_mrd));
    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({svc_mwr, svc_mrd}));
endmodule

// File: rtl/hp_host_rx.sv
module hp_host_rx #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          htx_we,
    input  logic [DW-1:0] htx_data,
    input  logic          host_re,
    input  logic          rd_set,
    output logic [DW-1:0] rx_data,
    output logic          full,
    output logic          pending
);
    typedef enum logic {RX_EMPTY, RX_FULL} rx_st_e;
    rx_st_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_EMPTY;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_EMPTY: if (htx_we)             st_nx = RX_FULL;
            RX_FULL:  if (host_re && !htx_we) st_nx = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            pending <= 1'b0;
        end else begin
            if (htx_we) rx_data <= htx_data;
            if (rd_set)
                pending <= 1'b1;
            else if (htx_we)
                pending <= 1'b0;
        end
    end

    assign full = (st == RX_FULL);

    p_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (htx_we && !rd_set) |=> (full && !pending && rx_data == $past(htx_data)));
    p_hostread_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && !htx_we) |=> !full);
    p_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_set |=> pending);
endmodule

// File: rtl/hpmem_bridge.sv
module hpmem_bridge
    import hpmem_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_tx_we,
    input  logic [1:0]    host_tx_func,
    input  logic [DW-1:0] host_tx_data,
    input  logic          host_rx_re,
    output logic [DW-1:0] host_rx_data,
    output logic          tx_empty,
    output logic          tx_ready,
    output logic          rx_full,
    output logic          host_req,
    output logic          ovr_err,
    output logic          rd_pending,
    input  logic          proc_hrx_re,
    output logic [DW-1:0] proc_hrx_data,
    output logic          proc_hrx_full,
    input  logic          proc_htx_we,
    input  logic [DW-1:0] proc_htx_data,
    output logic          svc_mwr,
    output logic          svc_mrd,
    output logic          wr_await_data
);
    logic          tx_full, hrx_full, move, rd_set;
    logic [DW-1:0] tx_word;
    hp_func_e      tx_tag;

    assign move = tx_full && !hrx_full;

    hp_tx_slot #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr(host_tx_we),
        .func(hp_func_e'(host_tx_func)), .din(host_tx_data),
        .drain(move), .full(tx_full), .word(tx_word), .tag(tx_tag),
        .err(ovr_err), .rd_set(rd_set)
    );

    hp_hrx_slot #(.DW(DW)) u_hrx (
        .clk(clk), .rst_n(rst_n), .load(move), .din(tx_word),
        .rd(proc_hrx_re), .full(hrx_full), .data(proc_hrx_data)
    );

    hp_wr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .land(move), .land_tag(tx_tag),
        .svc_mwr(svc_mwr), .svc_mrd(svc_mrd), .await_data(wr_await_data)
    );

    hp_host_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .htx_we(proc_htx_we),
        .htx_data(proc_htx_data), .host_re(host_rx_re), .rd_set(rd_set),
        .rx_data(host_rx_data), .full(rx_full), .pending(rd_pending)
    );

    assign tx_empty      = !tx_full;
    assign tx_ready      = !tx_full && !hrx_full;
    assign proc_hrx_full = hrx_full;
    assign host_req      = rx_full;

    p_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty && !proc_hrx_full) |=> (tx_empty && proc_hrx_full));
    p_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty && proc_hrx_full && !proc_hrx_re) |=> !tx_empty);
    p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        proc_hrx_full |-> !tx_ready);
    p_mrd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_mrd |=> !svc_mrd);
endmodule

// File: tb/hpmem_bridge_test.sv
`timescale 1ns/1ps
module hpmem_bridge_test;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_tx_we = 1'b0;
    logic [1:0]    host_tx_func = 2'b00;
    logic [DW-1:0] host_tx_data = '0;
    logic          host_rx_re = 1'b0;
    logic [DW-1:0] host_rx_data;
    logic          tx_empty, tx_ready, rx_full, host_req, ovr_err, rd_pending;
    logic          proc_hrx_re = 1'b0;
    logic [DW-1:0] proc_hrx_data;
    logic          proc_hrx_full;
    logic          proc_htx_we = 1'b0;
    logic [DW-1:0] proc_htx_data = '0;
    logic          svc_mwr, svc_mrd, wr_await_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hpmem_bridge #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .host_tx_we(host_tx_we),
        .host_tx_func(host_tx_func), .host_tx_data(host_tx_data),
        .host_rx_re(host_rx_re), .host_rx_data(host_rx_data),
        .tx_empty(tx_empty), .tx_ready(tx_ready), .rx_full(rx_full),
        .host_req(host_req), .ovr_err(ovr_err), .rd_pending(rd_pending),
        .proc_hrx_re(proc_hrx_re), .proc_hrx_data(proc_hrx_data),
        .proc_hrx_full(proc_hrx_full), .proc_htx_we(proc_htx_we),
        .proc_htx_data(proc_htx_data), .svc_mwr(svc_mwr), .svc_mrd(svc_mrd),
        .wr_await_data(wr_await_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one rising edge, then step 1 ns past it; inputs set before are captured
    task automatic tick();
        @(posedge clk);
        #1;
        host_tx_we  = 1'b0;
        host_rx_re  = 1'b0;
        proc_hrx_re = 1'b0;
        proc_htx_we = 1'b0;
    endtask

    task automatic push(input logic [1:0] f, input logic [DW-1:0] d);
        host_tx_we = 1'b1; host_tx_func = f; host_tx_data = d;
        tick();
    endtask

    task automatic hrx_read();
        proc_hrx_re = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        chk("R1", "tx_empty after reset", tx_empty, 1);
        chk("R4", "tx_ready after reset", tx_ready, 1);
        chk("R6", "rx_full after reset", rx_full, 0);
        chk("R7", "host_req after reset", host_req, 0);
        chk("R10", "ovr_err after reset", ovr_err, 0);
        chk("R5", "rd_pending after reset", rd_pending, 0);
        chk("R2", "hrx_full after reset", proc_hrx_full, 0);
    endtask

    task automatic t_plain();
        push(2'b00, 32'hA5A5_0001);
        chk("R1", "tx_empty after plain push", tx_empty, 0);
        chk("R4", "tx_ready with TX held", tx_ready, 0);
        tick();
        chk("R2", "tx_empty after move", tx_empty, 1);
        chk("R2", "hrx_full after move", proc_hrx_full, 1);
        chk("R2", "hrx data", proc_hrx_data, 32'hA5A5_0001);
        chk("R9", "no svc on plain", {svc_mwr, svc_mrd}, 0);
        chk("R4", "tx_ready with HRX full", tx_ready, 0);
        hrx_read();
        chk("R3", "hrx empty after read", proc_hrx_full, 0);
        chk("R4", "tx_ready both empty", tx_ready, 1);
    endtask

    task automatic t_backlog();
        push(2'b00, 32'h0000_1111);
        tick();
        push(2'b00, 32'h0000_2222);
        chk("R1", "second push held", tx_empty, 0);
        tick();
        chk("R3", "word waits while HRX full", tx_empty, 0);
        chk("R3", "HRX keeps first word", proc_hrx_data, 32'h0000_1111);
        hrx_read();
        chk("R3", "HRX empty after read", proc_hrx_full, 0);
        tick();
        chk("R3", "waiting word moved", proc_hrx_data, 32'h0000_2222);
        chk("R3", "tx_empty after backlog move", tx_empty, 1);
        chk("R10", "no overrun in backlog", ovr_err, 0);
        hrx_read();
    endtask

    task automatic t_memread();
        push(2'b10, 32'h0000_0C40);
        chk("R5", "rd_pending set", rd_pending, 1);
        chk("R5", "no svc before landing", svc_mrd, 0);
        tick();
        chk("R5", "svc_mrd on landing", svc_mrd, 1);
        chk("R5", "address in HRX", proc_hrx_data, 32'h0000_0C40);
        tick();
        chk("R5", "svc_mrd one cycle", svc_mrd, 0);
        chk("R5", "rd_pending held", rd_pending, 1);
        hrx_read();
        proc_htx_we = 1'b1; proc_htx_data = 32'hDEAD_BEEF;
        tick();
        chk("R6", "rx_full after HTX", rx_full, 1);
        chk("R6", "host_req after HTX", host_req, 1);
        chk("R6", "rx data", host_rx_data, 32'hDEAD_BEEF);
        chk("R6", "rd_pending cleared", rd_pending, 0);
        host_rx_re = 1'b1;
        tick();
        chk("R7", "rx_full after host read", rx_full, 0);
        chk("R7", "host_req after host read", host_req, 0);
        proc_htx_we = 1'b1; proc_htx_data = 32'h1234_5678;
        tick();
        host_rx_re = 1'b1; proc_htx_we = 1'b1; proc_htx_data = 32'h8765_4321;
        tick();
        chk("R7", "HTX wins over host read", rx_full, 1);
        chk("R7", "newest word kept", host_rx_data, 32'h8765_4321);
        host_rx_re = 1'b1;
        tick();
    endtask

    task automatic t_memwrite();
        chk("R11", "tx_ready before address", tx_ready, 1);
        push(2'b01, 32'h0000_0200);
        tick();
        chk("R8", "address raises no svc", svc_mwr, 0);
        chk("R8", "await data after address", wr_await_data, 1);
        push(2'b01, 32'hCAFE_0042);
        chk("R11", "data push no overrun", ovr_err, 0);
        chk("R11", "data push accepted", tx_empty, 0);
        tick();
        chk("R8", "data waits behind address", proc_hrx_data, 32'h0000_0200);
        hrx_read();
        tick();
        chk("R8", "svc_mwr on data landing", svc_mwr, 1);
        chk("R8", "data in HRX", proc_hrx_data, 32'hCAFE_0042);
        chk("R8", "await cleared", wr_await_data, 0);
        tick();
        chk("R8", "svc_mwr one cycle", svc_mwr, 0);
        hrx_read();
    endtask

    task automatic t_overrun();
        push(2'b00, 32'h0000_00AA);
        push(2'b00, 32'h0000_00BB);
        chk("R10", "ovr_err set", ovr_err, 1);
        chk("R10", "held word moved", proc_hrx_data, 32'h0000_00AA);
        tick();
        chk("R10", "ovr_err sticky", ovr_err, 1);
        hrx_read();
        tick();
        chk("R10", "dropped word never lands", proc_hrx_full, 0);
        chk("R10", "TX empty after drop", tx_empty, 1);
        push(2'b11, 32'hFFFF_FFFF);
        chk("R10", "ovr_err cleared", ovr_err, 0);
        chk("R10", "clear does not load TX", tx_empty, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_plain();
        t_backlog();
        t_memread();
        t_memwrite();
        t_overrun();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule